// File: doc/BRIEF.md
# Fractional 16x Oversampling Baud Tick Generator

This block turns an arbitrary system clock into a single-cycle enable pulse at sixteen times a chosen serial bit rate. One instance serves both the receive and the transmit side of a serial port. Both sides sample or shift on the same enable, so their timing bases always agree.

The pulse period is not found by rounding a divide ratio to an integer. The ratio of the oversampled rate to the clock is reduced by its greatest common divisor to two small integers. A step value is added to a phase register on every clock while the register is below a wrap threshold. When the register reaches the threshold, the threshold is subtracted instead and a pulse is issued. The pulses are therefore spread as evenly as the clock allows, and the long-term average rate equals the requested rate with no error. The clock frequency, the bit rate and the oversampling factor are elaboration-time parameters, and both derived constants are computed from them.

Top module: `baud_tick_gen16`

## Requirements
- R1: While `rst` is high at a rising edge, `tick` is low after that edge and the phase register is cleared. The first edge after reset is released never produces a tick.
- R2: At an edge where the phase register is below LIMIT, the register grows by STEP and `tick` is low after that edge.
- R3: At an edge where the phase register is at or above LIMIT, the register shrinks by LIMIT and `tick` is high for exactly that one cycle.
- R4: Over every run of STEP + LIMIT consecutive cycles after reset, `tick` is high in exactly STEP of them.
- R5: STEP = OVERSAMPLE·BAUD_HZ / g and LIMIT = CLK_HZ / g − STEP, where g = gcd(CLK_HZ, OVERSAMPLE·BAUD_HZ). The defaults (100 MHz clock, 288 000 baud, factor 16) give STEP = 144 (0x090) and LIMIT = 2981 (0xBA5).
- R6: The phase register always stays below STEP + LIMIT, so it never wraps around its width.
- R7: Counting edges from reset release as k = 1, 2, …, the tick at edge k is high exactly when floor(k·STEP/(STEP+LIMIT)) differs from floor((k−1)·STEP/(STEP+LIMIT)). Consecutive ticks are therefore separated by floor or ceil of (STEP+LIMIT)/STEP cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | output | 1 | One-cycle oversampling enable pulse |

## Verification
The bench builds three instances. The first uses the defaults (STEP 144, LIMIT 2981, period 3125), which exercises the uneven spacing of a large reduced ratio over two full periods. The second uses 1000 Hz with 50 baud (STEP 4, LIMIT 1). There STEP exceeds LIMIT, so ticks fall on adjacent cycles and the subtract branch runs back to back. The third uses 1600 Hz with 10 baud (STEP 1, LIMIT 9), an exact integer ratio where the generator must act as a plain divide-by-ten. A reset in the middle of a run checks that the pulse pattern restarts from the beginning.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    // Decision taken by the phase register on a clock edge
    typedef enum logic {
        PH_ACCUMULATE = 1'b0,
        PH_WRAP       = 1'b1
    } phase_e;

    function automatic longint unsigned gcd_u(input longint unsigned a_in,
                                              input longint unsigned b_in);
        longint unsigned a;
        longint unsigned b;
        longint unsigned t;
        a = a_in;
        b = b_in;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // Increment added while below the wrap threshold (R5)
    function automatic int unsigned step_of(input longint unsigned clk_hz,
                                            input longint unsigned baud_hz,
                                            input longint unsigned ovs);
        longint unsigned rate;
        rate = ovs * baud_hz;
        return int'(rate / gcd_u(clk_hz, rate));
    endfunction

    // Wrap threshold subtracted on a tick (R5)
    function automatic int unsigned limit_of(input longint unsigned clk_hz,
                                             input longint unsigned baud_hz,
                                             input longint unsigned ovs);
        longint unsigned rate;
        longint unsigned g;
        rate = ovs * baud_hz;
        g    = gcd_u(clk_hz, rate);
        return int'(clk_hz / g - rate / g);
    endfunction

endpackage

// File: rtl/baudgen_phase_acc.sv
module baudgen_phase_acc
    import baudgen_pkg::*;
#(
    parameter int unsigned STEP  = 144,
    parameter int unsigned LIMIT = 2981
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int unsigned PERIOD = STEP + LIMIT;
    localparam int          ACC_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [ACC_W-1:0] STEP_C  = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] LIMIT_C = ACC_W'(LIMIT);
    localparam logic [ACC_W-1:0] BOUND_C = ACC_W'(PERIOD - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             tick_q;
    phase_e           phase;

    always_comb begin
        phase = (acc_q < LIMIT_C) ? PH_ACCUMULATE : PH_WRAP;
        if (phase == PH_ACCUMULATE) begin
            acc_d = acc_q + STEP_C;
        end else begin
            acc_d = acc_q - LIMIT_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= (phase == PH_WRAP);
        end
    end

    assign tick_o = tick_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tick_q && acc_q == '0)) else $error("reset state broken"); // R1

    AST_ADD_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (acc_q < LIMIT_C) |=> (!tick_q && acc_q == $past(acc_q) + STEP_C))
        else $error("add branch broken"); // R2

    AST_WRAP_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (acc_q >= LIMIT_C) |=> (tick_q && acc_q == $past(acc_q) - LIMIT_C))
        else $error("wrap branch broken"); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acc_q <= BOUND_C) else $error("phase register out of range"); // R6

endmodule

// File: rtl/baud_tick_gen16.sv
module baud_tick_gen16
    import baudgen_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter longint unsigned BAUD_HZ    = 288_000,
    parameter longint unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int unsigned STEP   = step_of(CLK_HZ, BAUD_HZ, OVERSAMPLE);
    localparam int unsigned LIMIT  = limit_of(CLK_HZ, BAUD_HZ, OVERSAMPLE);
    localparam int unsigned PERIOD = STEP + LIMIT;

    baudgen_phase_acc #(
        .STEP  (STEP),
        .LIMIT (LIMIT)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    // Window checker: ticks seen in each aligned period after reset (R4)
    logic        started_q;
    int unsigned win_pos_q;
    int unsigned win_hits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q  <= 1'b0;
            win_pos_q  <= 0;
            win_hits_q <= 0;
        end else if (!started_q) begin
            started_q <= 1'b1;
        end else if (win_pos_q == PERIOD - 1) begin
            AST_WINDOW_COUNT: assert ((win_hits_q + int'(tick)) == STEP)
                else $error("tick count per period wrong"); // R4
            win_pos_q  <= 0;
            win_hits_q <= 0;
        end else begin
            win_pos_q  <= win_pos_q + 1;
            win_hits_q <= win_hits_q + int'(tick);
        end
    end

endmodule

// File: tb/sim_baud_tick_gen16.sv
`timescale 1ns/1ps
module sim_baud_tick_gen16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] tv;

    always #2.5 clk = ~clk;

    baud_tick_gen16 u0 (.clk(clk), .rst(rst), .tick(tv[0]));
    baud_tick_gen16 #(.CLK_HZ(1000), .BAUD_HZ(50), .OVERSAMPLE(16))
        u1 (.clk(clk), .rst(rst), .tick(tv[1]));
    baud_tick_gen16 #(.CLK_HZ(1600), .BAUD_HZ(10), .OVERSAMPLE(16))
        u2 (.clk(clk), .rst(rst), .tick(tv[2]));

    // Reduced constants from R5, computed by hand per instance
    longint fstep [3] = '{144, 4, 1};
    longint per   [3] = '{3125, 5, 10};

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint last_hit [3];
    longint win_pos  [3];
    longint win_hits [3];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_tick(input longint k, input longint f, input longint p);
        if (k < 1) return 1'b0;
        return ((k * f) / p) != (((k - 1) * f) / p);
    endfunction

    task automatic clear_track();
        for (int i = 0; i < 3; i++) begin
            last_hit[i] = 0;
            win_pos[i]  = 0;
            win_hits[i] = 0;
        end
    endtask

    task automatic step_check(input longint k);
        for (int i = 0; i < 3; i++) begin
            bit e;
            e = exp_tick(k, fstep[i], per[i]);
            // R7 exact pattern; also covers R2 (no tick) and R3 (tick) cycles
            chk(tv[i] == e, e ? "R3/R7 tick expected" : "R2/R7 no tick expected",
                tv[i], e);
            if (tv[i]) begin
                if (last_hit[i] > 0) begin
                    longint gap, lo, hi;
                    gap = k - last_hit[i];
                    lo  = per[i] / fstep[i];
                    hi  = (per[i] + fstep[i] - 1) / fstep[i];
                    chk(gap >= lo && gap <= hi, "R7 tick spacing", gap, lo);
                end
                last_hit[i] = k;
            end
            win_hits[i] += tv[i];
            win_pos[i]++;
            if (win_pos[i] == per[i]) begin
                // R4 and R5: STEP ticks per STEP+LIMIT cycles
                chk(win_hits[i] == fstep[i], "R4 ticks per period", win_hits[i], fstep[i]);
                win_pos[i]  = 0;
                win_hits[i] = 0;
            end
        end
    endtask

    initial begin
        longint k;
        clear_track();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tv == 3'b000, "R1 tick low in reset", tv, 0);
        rst = 1'b0;
        k = 0;
        repeat (6350) begin
            @(negedge clk);
            k++;
            step_check(k);
        end
        // Reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        chk(tv == 3'b000, "R1 tick cleared by reset", tv, 0);
        @(negedge clk);
        chk(tv == 3'b000, "R1 tick held low in reset", tv, 0);
        rst = 1'b0;
        clear_track();
        k = 0;
        @(negedge clk);
        k++;
        // R1: first edge after reset never ticks (all instances have LIMIT > 0)
        chk(tv == 3'b000, "R1 first edge quiet", tv, 0);
        step_check(k);
        repeat (3200) begin
            @(negedge clk);
            k++;
            step_check(k);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule